// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a down-counting watchdog with a small register set on a single-cycle bus. Software stores a reload value and then turns on the interrupt enable, the reset enable, or both. Setting either enable starts the counter. Software services the watchdog by writing the reload value again, which restarts the count.

The first time the count runs out, the block sets a pending flag, raises the interrupt if the interrupt is enabled, and restarts the count from the reload value. If the count runs out a second time while the flag is still pending and reset is enabled, the block raises a reset request. That request stays high until the block itself is reset. The pending flag is cleared only by a write to a separate clear register. A write of the right key unlocks the register set, and a write of any other value locks it.

Register map (word offsets on `reg_addr`): 0 reload value (read/write), 1 current count (read-only), 2 control (bit 0 interrupt enable, bit 1 reset enable), 3 flag clear (write-only, reads 0), 4 status (bit 0 pending flag, bit 1 masked interrupt), 5 lock (read bit 0 = locked).

Top module: `guard_wdt`

## Requirements
- R1: After `rst_n` is released: reload reads 0xFFFFFFFF, count reads 0xFFFFFFFF, control reads 0, status reads 0, lock reads 0, and `irq` and `sys_rst_req` are 0.
- R2: While both enables are clear, the count does not change unless the reload register (offset 0) is written.
- R3: While running, the count drops by one on each clock. In the cycle it is zero, the pending flag (status bit 0) is set and the count is reloaded. A reload write of L is followed by a timeout exactly L+1 clocks later.
- R4: A write to the reload register (offset 0) loads the written value into the count and leaves a pending flag set.
- R5: A write of any value to offset 3 clears the pending flag.
- R6: `irq` and status bit 1 equal the pending flag ANDed with the interrupt enable (control bit 0).
- R7: When a timeout happens with the flag already pending and reset enabled (control bit 1), `sys_rst_req` goes to 1. It stays at 1 until `rst_n` is asserted.
- R8: With reset enable clear, repeated timeouts never assert `sys_rst_req`.
- R9: Setting the interrupt enable from 0 to 1 loads the count from the reload register.
- R10: Control bits can only be set. Writing 0 to them has no effect.
- R11: A write of any value other than 0x1ACCE551 to offset 5 locks the block: lock reads 1, and writes to every other offset are ignored.
- R12: A write of exactly 0x1ACCE551 to offset 5 unlocks the block, and lock reads 0.
- R13: If a flag-clear write lands in the cycle the count is zero, that timeout is treated as a first timeout: the flag ends set and no reset request is raised. If a reload write lands in the cycle the count is zero, no timeout occurs and the count takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 3 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Masked interrupt |
| sys_rst_req | output | 1 | Sticky reset request |

## Verification
Two pairs of events can land in the same cycle. A flag-clear write can coincide with the zero count, and so can a reload write. The bench steps the count down to zero by whole clocks and issues the write on exactly that edge. It then judges the result from the status, count and reset-request outputs. For the clear collision the flag must be 1 with no reset request; for the reload collision the flag must be 0 with the new count. A sweep over small reload values checks, at every clock, that the count matches the reload value minus the elapsed clocks, and that the timeout lands L+1 clocks after the reload write.

// File: rtl/guard_wdt_pkg.sv
package guard_wdt_pkg;

  typedef enum logic [2:0] {
    OFS_RELOAD = 3'd0,
    OFS_COUNT  = 3'd1,
    OFS_CTRL   = 3'd2,
    OFS_CLEAR  = 3'd3,
    OFS_STATUS = 3'd4,
    OFS_LOCK   = 3'd5
  } wdt_ofs_e;

  localparam logic [31:0] UNLOCK_WORD = 32'h1ACC_E551;

  localparam int CTRL_IEN_BIT = 0;
  localparam int CTRL_REN_BIT = 1;

  typedef struct packed {
    logic ren;
    logic ien;
  } wdt_ctrl_t;

  function automatic logic key_matches(input logic [31:0] word);
    return word == UNLOCK_WORD;
  endfunction

  function automatic wdt_ctrl_t ctrl_merge(input wdt_ctrl_t cur, input logic [31:0] word);
    wdt_ctrl_t nxt;
    nxt.ien = cur.ien | word[CTRL_IEN_BIT];
    nxt.ren = cur.ren | word[CTRL_REN_BIT];
    return nxt;
  endfunction

endpackage

// File: rtl/guard_wdt_regs.sv
module guard_wdt_regs
  import guard_wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [DATA_W-1:0] RELOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] reload_q,
  output wdt_ctrl_t         ctrl_q,
  output logic              locked_q,
  output logic              reload_wr,
  output logic              clear_wr,
  output logic              ien_rise
);

  logic      open_wr;
  logic      lock_wr;
  logic      ctrl_wr;
  wdt_ctrl_t ctrl_nxt;

  assign lock_wr   = wr && (addr == ADDR_W'(OFS_LOCK));
  assign open_wr   = wr && !locked_q;
  assign reload_wr = open_wr && (addr == ADDR_W'(OFS_RELOAD));
  assign clear_wr  = open_wr && (addr == ADDR_W'(OFS_CLEAR));
  assign ctrl_wr   = open_wr && (addr == ADDR_W'(OFS_CTRL));
  assign ctrl_nxt  = ctrl_merge(ctrl_q, 32'(wdata));
  assign ien_rise  = ctrl_wr && !ctrl_q.ien && ctrl_nxt.ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= RELOAD_INIT;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (reload_wr) reload_q <= wdata;
      if (ctrl_wr)   ctrl_q   <= ctrl_nxt;
      if (lock_wr)   locked_q <= !key_matches(32'(wdata));
    end
  end

  p_ien_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.ien |=> ctrl_q.ien);
  p_ren_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.ren |=> ctrl_q.ren);
  p_lock_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr && addr != ADDR_W'(OFS_LOCK))
      |=> ($stable(reload_q) && $stable(ctrl_q)));
  p_key_opens_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && key_matches(32'(wdata))) |=> !locked_q);
  p_bad_key_locks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && !key_matches(32'(wdata))) |=> locked_q);

endmodule

// File: rtl/guard_wdt_counter.sv
module guard_wdt_counter #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RELOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic [DATA_W-1:0] reload_q,
  input  logic              reload_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ien_rise,
  output logic [DATA_W-1:0] count_q,
  output logic              expire
);

  function automatic logic [DATA_W-1:0] step_down(input logic [DATA_W-1:0] v);
    return v - DATA_W'(1);
  endfunction

  logic at_zero;
  assign at_zero = (count_q == '0);
  assign expire  = running && at_zero && !reload_wr && !ien_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= RELOAD_INIT;
    end else if (reload_wr) begin
      count_q <= wdata;
    end else if (ien_rise || expire) begin
      count_q <= reload_q;
    end else if (running) begin
      count_q <= step_down(count_q);
    end
  end

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !reload_wr && !ien_rise) |=> $stable(count_q));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !at_zero && !reload_wr && !ien_rise) |=> (count_q == $past(count_q) - DATA_W'(1)));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count_q == $past(reload_q)));
  p_preload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ien_rise |=> (count_q == $past(reload_q)));
  p_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> (count_q == $past(wdata)));

endmodule

// File: rtl/guard_wdt_events.sv
module guard_wdt_events (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clear_wr,
  input  logic reload_wr,
  input  logic ien,
  input  logic ren,
  output logic pend_q,
  output logic irq,
  output logic rst_req_q
);

  logic second_hit;
  assign second_hit = expire && pend_q && !clear_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (expire)        pend_q <= 1'b1;
      else if (clear_wr) pend_q <= 1'b0;
      if (second_hit && ren) rst_req_q <= 1'b1;
    end
  end

  assign irq = pend_q & ien;

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && !expire) |=> !pend_q);
  p_reload_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_wr && pend_q) |=> pend_q);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> rst_req_q);
  p_needs_ren_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_q) |-> ren);
  p_collide_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && expire && !rst_req_q) |=> (pend_q && !rst_req_q));
  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

endmodule

// File: rtl/guard_wdt.sv
module guard_wdt
  import guard_wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [DATA_W-1:0] RELOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              sys_rst_req
);

  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] count_q;
  wdt_ctrl_t         ctrl_q;
  logic              locked_q;
  logic              reload_wr;
  logic              clear_wr;
  logic              ien_rise;
  logic              expire;
  logic              pend_q;
  logic              running;

  assign running = ctrl_q.ien | ctrl_q.ren;

  guard_wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RELOAD_INIT(RELOAD_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .reload_q(reload_q), .ctrl_q(ctrl_q), .locked_q(locked_q),
    .reload_wr(reload_wr), .clear_wr(clear_wr), .ien_rise(ien_rise)
  );

  guard_wdt_counter #(.DATA_W(DATA_W), .RELOAD_INIT(RELOAD_INIT)) u_count (
    .clk(clk), .rst_n(rst_n), .running(running), .reload_q(reload_q),
    .reload_wr(reload_wr), .wdata(reg_wdata), .ien_rise(ien_rise),
    .count_q(count_q), .expire(expire)
  );

  guard_wdt_events u_events (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clear_wr(clear_wr),
    .reload_wr(reload_wr), .ien(ctrl_q.ien), .ren(ctrl_q.ren),
    .pend_q(pend_q), .irq(irq), .rst_req_q(sys_rst_req)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_RELOAD): reg_rdata = reload_q;
      ADDR_W'(OFS_COUNT):  reg_rdata = count_q;
      ADDR_W'(OFS_CTRL):   begin
        reg_rdata[CTRL_IEN_BIT] = ctrl_q.ien;
        reg_rdata[CTRL_REN_BIT] = ctrl_q.ren;
      end
      ADDR_W'(OFS_STATUS): begin
        reg_rdata[0] = pend_q;
        reg_rdata[1] = irq;
      end
      ADDR_W'(OFS_LOCK):   reg_rdata[0] = locked_q;
      default:             reg_rdata = '0;
    endcase
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !expire);
  p_lock_blocks_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && reg_wr && reg_addr == ADDR_W'(OFS_CLEAR) && pend_q) |=> pend_q);

endmodule

// File: tb/guard_wdt_test.sv
module guard_wdt_test;

  localparam logic [2:0] A_RELOAD = 3'd0;
  localparam logic [2:0] A_COUNT  = 3'd1;
  localparam logic [2:0] A_CTRL   = 3'd2;
  localparam logic [2:0] A_CLEAR  = 3'd3;
  localparam logic [2:0] A_STATUS = 3'd4;
  localparam logic [2:0] A_LOCK   = 3'd5;
  localparam logic [31:0] KEY     = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        sys_rst_req;

  int n_run = 0;
  int n_bad = 0;

  guard_wdt uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sys_rst_req(sys_rst_req)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    expect_reg("R1 reload", A_RELOAD, 32'hFFFFFFFF);
    expect_reg("R1 count", A_COUNT, 32'hFFFFFFFF);
    expect_reg("R1 ctrl", A_CTRL, 0);
    expect_reg("R1 status", A_STATUS, 0);
    expect_reg("R1 lock", A_LOCK, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 rst_req", {31'd0, sys_rst_req}, 0);

    // R2 idle hold
    wr(A_RELOAD, 5);
    tick(10);
    expect_reg("R2 idle count", A_COUNT, 5);
    expect_reg("R2 idle status", A_STATUS, 0);

    // R9 enable preloads, R3/R6 first timeout
    wr(A_CTRL, 1);
    expect_reg("R9 preload", A_COUNT, 5);
    tick(5);
    expect_reg("R3 at zero", A_COUNT, 0);
    check("R6 irq before", {31'd0, irq}, 0);
    tick(1);
    expect_reg("R3 timeout status", A_STATUS, 3);
    expect_reg("R3 reloaded", A_COUNT, 5);
    check("R6 irq", {31'd0, irq}, 1);

    // R3/R5 sweep over reload values
    for (int L = 0; L <= 6; L++) begin
      wr(A_RELOAD, 100);
      wr(A_CLEAR, 32'hDEAD);
      expect_reg("R5 cleared", A_STATUS, 0);
      check("R5 irq cleared", {31'd0, irq}, 0);
      wr(A_RELOAD, 32'(L));
      for (int k = 0; k <= L; k++) begin
        expect_reg("R3 count step", A_COUNT, 32'(L - k));
        expect_reg("R3 no early timeout", A_STATUS, 0);
        tick(1);
      end
      expect_reg("R3 sweep timeout", A_STATUS, 3);
      expect_reg("R3 sweep reload", A_COUNT, 32'(L));
    end

    // R4 reload keeps pending flag
    wr(A_RELOAD, 50);
    expect_reg("R4 flag kept", A_STATUS, 3);
    expect_reg("R4 count", A_COUNT, 50);

    // R8 second timeout without reset enable
    wr(A_RELOAD, 3);
    tick(4);
    expect_reg("R8 second timeout seen", A_COUNT, 3);
    check("R8 no rst_req", {31'd0, sys_rst_req}, 0);

    // R10 enables are set-only
    wr(A_CTRL, 0);
    expect_reg("R10 ctrl kept", A_CTRL, 1);

    // R13 reload at zero
    wr(A_RELOAD, 100);
    wr(A_CLEAR, 0);
    wr(A_RELOAD, 2);
    tick(2);
    expect_reg("R13 zero reached", A_COUNT, 0);
    wr(A_RELOAD, 7);
    expect_reg("R13 reload wins count", A_COUNT, 7);
    expect_reg("R13 reload wins status", A_STATUS, 0);

    wr(A_CTRL, 2);
    expect_reg("R10 ctrl both", A_CTRL, 3);

    // R13 clear at zero
    wr(A_RELOAD, 2);
    tick(3);
    expect_reg("R13 first timeout", A_STATUS, 3);
    check("R13 no rst yet", {31'd0, sys_rst_req}, 0);
    tick(2);
    wr(A_CLEAR, 1);
    expect_reg("R13 clear vs expiry flag", A_STATUS, 3);
    check("R13 clear vs expiry rst", {31'd0, sys_rst_req}, 0);
    expect_reg("R13 count", A_COUNT, 2);

    // R7 second timeout with reset enabled
    tick(2);
    check("R7 not before", {31'd0, sys_rst_req}, 0);
    tick(1);
    check("R7 rst_req", {31'd0, sys_rst_req}, 1);
    wr(A_CLEAR, 0);
    tick(10);
    check("R7 sticky", {31'd0, sys_rst_req}, 1);

    // R11/R12 lock
    wr(A_LOCK, 0);
    expect_reg("R11 locked", A_LOCK, 1);
    wr(A_RELOAD, 9);
    expect_reg("R11 reload ignored", A_RELOAD, 2);
    wr(A_LOCK, KEY - 1);
    expect_reg("R12 wrong key", A_LOCK, 1);
    wr(A_LOCK, KEY);
    expect_reg("R12 unlocked", A_LOCK, 0);
    wr(A_RELOAD, 9);
    expect_reg("R12 reload writable", A_RELOAD, 9);

    // R7 cleared only by block reset
    do_reset();
    check("R7 reset clears", {31'd0, sys_rst_req}, 0);
    expect_reg("R1 ctrl after reset", A_CTRL, 0);
    expect_reg("R1 lock after reset", A_LOCK, 0);

    // R11 locked ctrl write ignored
    wr(A_LOCK, 32'h5);
    wr(A_CTRL, 3);
    expect_reg("R11 ctrl ignored", A_CTRL, 0);
    wr(A_LOCK, KEY);

    // R9 interrupt enable after reset-only run
    wr(A_RELOAD, 20);
    wr(A_CTRL, 2);
    expect_reg("R2 start count", A_COUNT, 20);
    tick(5);
    expect_reg("R3 running ren only", A_COUNT, 15);
    wr(A_CTRL, 1);
    expect_reg("R9 ien preload", A_COUNT, 20);
    expect_reg("R9 ctrl", A_CTRL, 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule